// File: doc/BRIEF.md
# Sector Page-Load Program Sequencer

This block sits on the device side of a parallel, flash-style memory port. A host writes a burst of bytes that all belong to one 256-byte sector. The block gathers them in a page buffer and then runs a timed internal program phase that commits them to the storage array. The load phase has no commit command. It ends when no new write arrives within a fixed window after the previous write finished. From that point `busy` is high for a fixed program time. During that time every read returns a status byte instead of array contents, so the host can poll for completion.

The port is strobed, not valid/ready. A write is a window in which the write and chip strobes are both low while the output enable is high. A read is a window in which the chip strobe and output enable are both low while the write strobe is high. The block gives no back-pressure. The host must respect the load window and poll `busy` or the status byte before it starts a new load. Writes that arrive while `busy` is high are dropped.

Both time windows are given in microseconds and converted to clock cycles from `CLK_HZ`. The storage array is a behavioural register model that holds `ARR_SECT` sectors, and `ARR_SECT` must be a power of two. It is indexed by the low bits of the sector field, so higher sector numbers alias onto it.

Top module: `sector_load_prog`

## Requirements
- R1: After reset, `busy` and `sect_err` are 0, `rdata` is 0 while no read is active, and every array byte reads 0xFF.
- R2: A write starts on the first clock where we_n=0, ce_n=0 and oe_n=1. At that point the address is latched. The write ends on the first clock where that condition is gone, and `wdata` is taken at that point. If oe_n is low, the write is inhibited and no load begins.
- R3: Address bits [17:8] form the sector number and bits [7:0] the byte offset. The sector is taken from the first write of a load. Offsets may arrive in any order, and a repeated offset keeps the last value written.
- R4: A write that starts fewer than WIN_CYC clocks after the previous write ended joins the same load, and `busy` stays 0.
- R5: If no write starts within WIN_CYC clocks after the previous write ended, `busy` rises and the program phase begins.
- R6: `busy` stays high for PROG_CYC clocks and then falls. The committed bytes are readable from then on.
- R7: Only the offsets written in a load change. All other bytes keep their previous values.
- R8: During a load, a write whose sector differs from the latched sector is dropped and sets `sect_err`. `sect_err` stays set until the next load starts.
- R9: While `busy` is high, a read returns a status byte. Bit 7 is the inverse of bit 7 of the last byte loaded. Bit 6 changes after each completed read. Bits 5:0 are 0.
- R10: Writes that occur while `busy` is high change no array byte.
- R11: Outside the program phase, `rdata` shows the array byte at `addr` one clock after the read starts. It shows 0 when no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Write strobe, active low |
| ce_n | input | 1 | Chip strobe, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | SEC_W+OFS_W | Sector number and byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or status byte |
| busy | output | 1 | Program phase in progress |
| sect_err | output | 1 | Sticky flag for a dropped wrong-sector write |

## Verification
The assertions check the following on every cycle:
- the program phase can only be entered from a load;
- `busy` falls only when the program timer expires;
- the latched sector stays fixed during a load;
- the written-offset mask stays frozen while programming;
- `sect_err` clears only when a new load starts;
- a low output enable keeps an idle block idle.

Only the bench scenarios can show the rest:
- the exact window and program lengths measured in clocks;
- out-of-order and repeated offsets landing in the array;
- unwritten bytes surviving a program;
- the inverted and toggling status bits;
- writes during `busy` leaving the array unchanged.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } slp_state_e;

  // microseconds to clock cycles, ordered to stay inside 32-bit range
  function automatic int us_to_cycles(input int clk_hz, input int us);
    int c;
    c = ((clk_hz / 1000) * us) / 1000;
    return (c < 2) ? 2 : c;
  endfunction
endpackage

// File: rtl/slp_timer.sv
module slp_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // counts clocks while enabled, restarts from zero whenever disabled
  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = en && (cnt_q == LAST);
endmodule

// File: rtl/slp_edge.sv
module slp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  output logic start,
  output logic stop
);
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign start = act && !act_q;
  assign stop  = !act && act_q;
endmodule

// File: rtl/slp_page.sv
module slp_page #(
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           wr,
  input  logic [OFS_W-1:0]               wr_ofs,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [(1<<OFS_W)-1:0]          mask,
  output logic [(1<<OFS_W)-1:0][DATA_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      mask <= '0;
    end else if (wr) begin
      mask[wr_ofs] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) data[wr_ofs] <= wr_data;
  end
endmodule

// File: rtl/sector_load_prog.sv
module sector_load_prog
  import slp_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int WIN_US   = 150,
  parameter int PROG_US  = 10_000,
  parameter int OFS_W    = 8,
  parameter int SEC_W    = 10,
  parameter int ARR_SECT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_n,
  input  logic                    ce_n,
  input  logic                    oe_n,
  input  logic [SEC_W+OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  output logic                    busy,
  output logic                    sect_err
);
  localparam int ADDR_W    = SEC_W + OFS_W;
  localparam int PAGE      = 1 << OFS_W;
  localparam int WIN_CYC   = us_to_cycles(CLK_HZ, WIN_US);
  localparam int PROG_CYC  = us_to_cycles(CLK_HZ, PROG_US);
  localparam int SIDX_W    = (ARR_SECT > 1) ? $clog2(ARR_SECT) : 1;
  localparam int ARR_DEPTH = ARR_SECT * PAGE;

  slp_state_e state_q, state_d;
  logic [SEC_W-1:0]  sect_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              pend_q;
  logic [DATA_W-1:0] last_q;
  logic              err_q;
  logic              tog_q;
  logic              rd_q;
  logic [DATA_W-1:0] arr [ARR_DEPTH];

  logic wr_act, wr_start, wr_stop, rd_act, rd_end;
  logic sect_hit, load_open, page_wr, win_exp, prog_exp;
  logic [PAGE-1:0]             page_mask;
  logic [PAGE-1:0][DATA_W-1:0] page_data;

  assign wr_act = !we_n && !ce_n && oe_n;
  assign rd_act = we_n && !ce_n && !oe_n;
  assign rd_end = rd_q && !rd_act;

  slp_edge u_wr_edge (
    .clk(clk), .rst_n(rst_n), .act(wr_act), .start(wr_start), .stop(wr_stop)
  );

  slp_timer #(.LIMIT(WIN_CYC)) u_win_tmr (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_LOAD && !pend_q), .expired(win_exp)
  );

  slp_timer #(.LIMIT(PROG_CYC)) u_prog_tmr (
    .clk(clk), .rst_n(rst_n), .en(state_q == ST_PROG), .expired(prog_exp)
  );

  assign sect_hit  = (addr[ADDR_W-1:OFS_W] == sect_q);
  assign load_open = (state_q == ST_IDLE) && wr_start;
  assign page_wr   = (state_q == ST_LOAD) && wr_stop && pend_q;

  slp_page #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(load_open), .wr(page_wr),
    .wr_ofs(ofs_q), .wr_data(wdata), .mask(page_mask), .data(page_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (wr_start) state_d = ST_LOAD;
      ST_LOAD: if (!(wr_start && sect_hit) && win_exp) state_d = ST_PROG;
      ST_PROG: if (prog_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sect_q  <= '0;
      ofs_q   <= '0;
      pend_q  <= 1'b0;
      last_q  <= '0;
      err_q   <= 1'b0;
      tog_q   <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_act;
      unique case (state_q)
        ST_IDLE: if (wr_start) begin
          sect_q <= addr[ADDR_W-1:OFS_W];
          ofs_q  <= addr[OFS_W-1:0];
          pend_q <= 1'b1;
          err_q  <= 1'b0;
        end
        ST_LOAD: begin
          if (wr_start) begin
            if (sect_hit) begin
              ofs_q  <= addr[OFS_W-1:0];
              pend_q <= 1'b1;
            end else begin
              err_q <= 1'b1;
            end
          end
          if (page_wr) begin
            last_q <= wdata;
            pend_q <= 1'b0;
          end
        end
        ST_PROG: begin
          pend_q <= 1'b0;
          if (rd_end) tog_q <= !tog_q;
        end
        default: pend_q <= 1'b0;
      endcase
    end
  end

  // array model: erased at reset, loaded offsets committed at end of program
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_DEPTH; i++) arr[i] <= '1;
    end else if (state_q == ST_PROG && prog_exp) begin
      for (int i = 0; i < PAGE; i++)
        if (page_mask[i]) arr[{sect_q[SIDX_W-1:0], OFS_W'(i)}] <= page_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rd_act)     rdata <= '0;
    else if (state_q == ST_PROG) rdata <= {~last_q[DATA_W-1], tog_q, {(DATA_W-2){1'b0}}};
    else                       rdata <= arr[{addr[OFS_W +: SIDX_W], addr[OFS_W-1:0]}];
  end

  assign busy     = (state_q == ST_PROG);
  assign sect_err = err_q;

  // R5: the program phase is only ever entered from a load
  a_r5_prog_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(state_q == ST_LOAD));

  // R6: busy ends only when the program timer has run out
  a_r6_busy_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(prog_exp));

  // R3: sector stays locked for the whole load
  a_r3_sector_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && $past(state_q == ST_LOAD)) |-> $stable(sect_q));

  // R10: nothing is added to the page while programming
  a_r10_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && $past(state_q == ST_PROG)) |-> $stable(page_mask));

  // R8: error flag is cleared only when a load begins from idle
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sect_err) |-> $past(state_q == ST_IDLE));

  // R2: a low output enable keeps an idle block idle
  a_r2_oe_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !oe_n) |=> (state_q == ST_IDLE));
endmodule

// File: tb/tb_sector_load_prog.sv
module tb_sector_load_prog;
  localparam int CLK_HZ  = 1_000_000;   // scaled time base: windows in cycles stay short
  localparam int WIN_US  = 150;
  localparam int PROG_US = 300;
  localparam int WIN     = 150;
  localparam int PROG    = 300;

  // table entry: {offset, data, gap cycles after the write}, all in sector 1
  localparam logic [31:0] TBL [8] = '{
    {8'h40, 8'hA5, 16'd20},
    {8'h03, 8'h3C, 16'd100},
    {8'hFE, 8'h81, 16'd140},
    {8'h40, 8'h5A, 16'd10},
    {8'h00, 8'h00, 16'd5},
    {8'hFF, 8'h7E, 16'd60},
    {8'h10, 8'hC3, 16'd1},
    {8'h80, 8'h18, 16'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy, sect_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [4][256];

  always #10 clk = !clk;

  sector_load_prog #(.CLK_HZ(CLK_HZ), .WIN_US(WIN_US), .PROG_US(PROG_US)) dut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .sect_err(sect_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr_byte(input logic [9:0] sec, input logic [7:0] ofs, input logic [7:0] d,
                         input logic oe);
    @(negedge clk);
    addr = {sec, ofs}; wdata = d; oe_n = oe; we_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_byte(input logic [9:0] sec, input logic [7:0] ofs, output logic [7:0] d);
    @(negedge clk);
    addr = {sec, ofs}; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = rdata;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_busy(input logic v, output int cyc);
    cyc = 0;
    while (busy !== v && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_sector(input int s, input string req);
    logic [7:0] d;
    for (int o = 0; o < 256; o++) begin
      rd_byte(10'(s), 8'(o), d);
      chk(req, d, mdl[s][o]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d, s1, s2;
    int t1, t2;
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 256; o++) mdl[s][o] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 sect_err", sect_err, 0);
    chk("R1 rdata idle", rdata, 0);
    rd_byte(10'd1, 8'h40, d); chk("R1 erased byte", d, 8'hFF);
    rd_byte(10'd3, 8'hFF, d); chk("R1 erased byte", d, 8'hFF);

    // R3 R4: table-driven load of sector 1, out of order with a repeated offset
    foreach (TBL[i]) begin
      wr_byte(10'd1, TBL[i][31:24], TBL[i][23:16], 1'b1);
      mdl[1][TBL[i][31:24]] = TBL[i][23:16];
      repeat (int'(TBL[i][15:0])) @(negedge clk);
      if (i < 7) chk("R4 load stays open", busy, 0);
    end
    chk("R8 no error on same sector", sect_err, 0);

    // R5 R6: window and program length
    wait_busy(1'b1, t1);
    chk_rng("R5 window length", t1, WIN - 2, WIN + 3);
    wait_busy(1'b0, t2);
    chk_rng("R6 program length", t2, PROG - 2, PROG + 2);

    // R3 R7 R11: readback of committed and untouched bytes
    check_sector(1, "R7 sector 1 after load");
    rd_byte(10'd0, 8'h40, d); chk("R7 other sector untouched", d, 8'hFF);

    // R8: wrong sector write inside a load
    wr_byte(10'd1, 8'h03, 8'h99, 1'b1); mdl[1][8'h03] = 8'h99;
    repeat (5) @(negedge clk);
    wr_byte(10'd2, 8'h03, 8'h55, 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 error set", sect_err, 1);
    wr_byte(10'd1, 8'h77, 8'h80, 1'b1); mdl[1][8'h77] = 8'h80;
    wait_busy(1'b1, t1);
    chk("R8 error sticky", sect_err, 1);

    // R9: status reads while busy (last byte 0x80)
    rd_byte(10'd1, 8'h77, s1);
    rd_byte(10'd1, 8'h77, s2);
    chk("R9 inverted bit7", s1[7], 1'b0);
    chk("R9 toggle bit", s1[6] ^ s2[6], 1'b1);
    chk("R9 low bits zero", {s1[5:0], s2[5:0]}, 0);

    // R10: write during busy is dropped
    wr_byte(10'd1, 8'h20, 8'h44, 1'b1);
    wait_busy(1'b0, t2);
    check_sector(1, "R10 sector 1 after second load");
    rd_byte(10'd2, 8'h03, d); chk("R8 wrong sector byte dropped", d, 8'hFF);
    chk("R8 error held after program", sect_err, 1);

    // R2: write with output enable low is inhibited
    wr_byte(10'd0, 8'h05, 8'h11, 1'b0);
    repeat (WIN + 20) @(negedge clk);
    chk("R2 inhibited write starts no load", busy, 0);
    rd_byte(10'd0, 8'h05, d); chk("R2 inhibited byte", d, 8'hFF);
    chk("R8 error held without new load", sect_err, 1);

    // R8: new load clears the error; R7 neighbour untouched
    wr_byte(10'd0, 8'h05, 8'h2A, 1'b1);
    chk("R8 error cleared by new load", sect_err, 0);
    wait_busy(1'b1, t1);
    wait_busy(1'b0, t2);
    rd_byte(10'd0, 8'h05, d); chk("R6 committed byte", d, 8'h2A);
    rd_byte(10'd0, 8'h06, d); chk("R7 neighbour kept", d, 8'hFF);
    chk("R11 rdata idle after reads", rdata, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule